// File: doc/BRIEF.md
# Serial Line Mode and Control

This block holds the byte-wide line control register of a UART and uses it to steer the serial paths. The paths run between the line pins, the transmitter shift path and the receiver shift path. A CPU writes the register through a simple write strobe.

The register selects one of four line modes:
- normal wiring;
- a forced break on the output line;
- echo of the input line straight back to the output;
- an internal loop from the transmitter to the receiver for self test.

The register also controls a receiver gate. It drives two active-low handshake pins, request-to-send and data-terminal-ready. It holds two interrupt enable bits that the status logic uses.

All path steering is combinational from the register. The echo path in particular has no flop between the input pin and the output pin. Shift registers, baud timing and status flags sit outside this block.

Top module: `line_mode_ctl`

## Requirements
- R1: After reset the register is zero. This gives normal mode with the receiver gated off. rts_n and dtr_n are 1, both enable outputs are 0, and rx_serial is 1.
- R2: The register loads wr_data on a rising clock edge where wr_en is 1, and holds its value otherwise. Field positions are: bit 0 RTS, bit 1 DTR, bit 2 interrupt enable, bits 4:3 mode, bit 5 receiver enable, bit 6 modem interrupt enable, bit 7 reserved.
- R3: In mode 00 (normal), sdo equals tx_serial, and the receiver source is sdi.
- R4: In mode 01 (break), sdo is 0 for as long as the mode stays selected, whatever tx_serial does.
- R5: In mode 10 (echo), sdo equals sdi combinationally, without a clock edge, and tx_serial has no effect on sdo. The receiver source is sdi.
- R6: In mode 11 (loop), the receiver source is tx_serial, sdo is held at 1, and sdi has no effect.
- R7: When the receiver enable bit is 0, rx_serial is 1 in every mode.
- R8: rts_n is the inverse of register bit 0, and dtr_n is the inverse of register bit 1.
- R9: int_en follows register bit 2, and modem_int_en follows register bit 6.
- R10: A 1 written to bit 7 has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write value |
| tx_serial | input | 1 | Serial bit from the transmitter |
| sdi | input | 1 | Serial input pin |
| sdo | output | 1 | Serial output pin |
| rx_serial | output | 1 | Serial bit to the receiver |
| rts_n | output | 1 | Request-to-send pin, active low |
| dtr_n | output | 1 | Data-terminal-ready pin, active low |
| int_en | output | 1 | Interrupt enable to status logic |
| modem_int_en | output | 1 | Modem interrupt enable to status logic |

## Verification
The hardest case to reach from the ports is proving that echo has no flop in its path. The bench selects echo mode, then toggles sdi between clock edges and samples sdo at once. A registered echo would lag by a cycle and fail.

The table also pairs each mode with tx_serial and sdi values that disagree. This way a mis-steered path shows up as a wrong level and cannot be hidden by a coincidental one.

// File: rtl/line_mode_ctl.sv
module line_mode_ctl #(
  parameter logic [7:0] RESET_VAL = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       tx_serial,
  input  logic       sdi,
  output logic       sdo,
  output logic       rx_serial,
  output logic       rts_n,
  output logic       dtr_n,
  output logic       int_en,
  output logic       modem_int_en
);

  localparam logic [1:0] M_NORM  = 2'b00;
  localparam logic [1:0] M_BREAK = 2'b01;
  localparam logic [1:0] M_ECHO  = 2'b10;
  localparam logic [1:0] M_LOOP  = 2'b11;

  logic [6:0] ctl_q;
  logic [1:0] mode;
  logic       rx_src;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     ctl_q <= RESET_VAL[6:0];
    else if (wr_en) ctl_q <= wr_data[6:0];

  assign mode = ctl_q[4:3];

  always_comb begin
    case (mode)
      M_NORM:  sdo = tx_serial;
      M_BREAK: sdo = 1'b0;
      M_ECHO:  sdo = sdi;
      M_LOOP:  sdo = 1'b1;
      default: sdo = 1'b1;
    endcase
  end

  assign rx_src       = (mode == M_LOOP) ? tx_serial : sdi;
  assign rx_serial    = ctl_q[5] ? rx_src : 1'b1;
  assign rts_n        = ~ctl_q[0];
  assign dtr_n        = ~ctl_q[1];
  assign int_en       = ctl_q[2];
  assign modem_int_en = ctl_q[6];

endmodule

module line_mode_ctl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [7:0] wr_data,
  input logic       tx_serial,
  input logic       sdi,
  input logic       sdo,
  input logic       rx_serial,
  input logic       rts_n,
  input logic       dtr_n,
  input logic       int_en,
  input logic       modem_int_en
);

  logic [7:0] shadow;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     shadow <= 8'h00;
    else if (wr_en) shadow <= {1'b0, wr_data[6:0]};

  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (rts_n && dtr_n && !int_en && !modem_int_en && rx_serial));
  // R3
  normal_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[4:3] == 2'b00) |-> (sdo == tx_serial));
  // R4
  break_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[4:3] == 2'b01) |-> !sdo);
  // R5
  echo_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[4:3] == 2'b10) |-> (sdo == sdi));
  // R6
  loop_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (shadow[4:3] == 2'b11 && shadow[5]) |-> (sdo && rx_serial == tx_serial));
  // R7
  rx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shadow[5] |-> rx_serial);
  // R8
  hs_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_n != shadow[0]) && (dtr_n != shadow[1]));
  // R9
  enables_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int_en == shadow[2]) && (modem_int_en == shadow[6]));
  // R2
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> ($stable(rts_n) && $stable(dtr_n) && $stable(int_en) && $stable(modem_int_en)));

endmodule

bind line_mode_ctl line_mode_ctl_chk u_chk (.*);

// File: tb/sim_line_mode_ctl.sv
module sim_line_mode_ctl;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, wr_en = 0, tx_serial = 1, sdi = 1;
  logic [7:0] wr_data = 0;
  logic sdo, rx_serial, rts_n, dtr_n, int_en, modem_int_en;
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  line_mode_ctl u0 (.*);

  // {ctl, tx, sdi, exp_sdo, exp_rx}
  localparam int NV = 13;
  localparam logic [11:0] VEC [NV] = '{
    {8'h20, 1'b0, 1'b1, 1'b0, 1'b1},
    {8'h20, 1'b1, 1'b0, 1'b1, 1'b0},
    {8'h00, 1'b0, 1'b0, 1'b0, 1'b1},
    {8'h28, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h28, 1'b1, 1'b1, 1'b0, 1'b1},
    {8'h30, 1'b1, 1'b0, 1'b0, 1'b0},
    {8'h30, 1'b0, 1'b1, 1'b1, 1'b1},
    {8'h38, 1'b0, 1'b1, 1'b1, 1'b0},
    {8'h38, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h18, 1'b0, 1'b0, 1'b1, 1'b1},
    {8'h47, 1'b1, 1'b0, 1'b1, 1'b1},
    {8'h65, 1'b0, 1'b0, 1'b0, 1'b0},
    {8'h12, 1'b0, 1'b0, 1'b0, 1'b1}
  };

  task automatic chk(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] v);
    @(negedge clk); wr_data = v; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic chk_ctl(logic [7:0] c);
    chk("R8 rts_n", rts_n, ~c[0]);
    chk("R8 dtr_n", dtr_n, ~c[1]);
    chk("R9 int_en", int_en, c[2]);
    chk("R9 modem_int_en", modem_int_en, c[6]);
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    tx_serial = 0; sdi = 0; #1;
    chk("R1 rx_serial", rx_serial, 1'b1);
    chk("R1 sdo normal", sdo, 1'b0);
    chk_ctl(8'h00);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][11:4]);
      tx_serial = VEC[i][3]; sdi = VEC[i][2]; #1;
      chk($sformatf("R3-R7 vec%0d sdo", i), sdo, VEC[i][1]);
      chk($sformatf("R7 vec%0d rx_serial", i), rx_serial, VEC[i][0]);
      chk_ctl(VEC[i][11:4]);
    end

    // R2: no write without strobe
    wr(8'h47);
    @(negedge clk); wr_data = 8'h38; wr_en = 0;
    @(negedge clk); tx_serial = 0; #1;
    chk("R2 hold sdo", sdo, 1'b0);
    chk_ctl(8'h47);

    // R10: bit 7 ignored
    wr(8'hA0); tx_serial = 1; sdi = 0; #1;
    chk("R10 sdo", sdo, 1'b1);
    chk("R10 rx_serial", rx_serial, 1'b0);
    chk_ctl(8'h20);

    // R5: echo is combinational
    wr(8'h30); tx_serial = 0;
    @(negedge clk);
    #2 sdi = 1; #1 chk("R5 echo rise", sdo, 1'b1);
    #1 sdi = 0; #1 chk("R5 echo fall", sdo, 1'b0);
    tx_serial = 1; #1 chk("R5 tx blocked", sdo, 1'b0);

    // R4: break held over many cycles
    wr(8'h08);
    for (int k = 0; k < 6; k++) begin
      tx_serial = k[0]; @(negedge clk);
      chk("R4 break hold", sdo, 1'b0);
    end

    // R6: sdi ignored in loop
    wr(8'h38); tx_serial = 0;
    for (int k = 0; k < 2; k++) begin
      sdi = k[0]; #1;
      chk("R6 loop rx", rx_serial, 1'b0);
      chk("R6 loop sdo", sdo, 1'b1);
    end

    // R1: reset mid-run
    wr(8'h67);
    #2 rst_n = 0; #1;
    chk("R1 reset rx", rx_serial, 1'b1);
    chk_ctl(8'h00);
    tx_serial = 1; #1 chk("R1 reset normal sdo", sdo, 1'b1);
    @(negedge clk); rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule